// File: doc/BRIEF.md
# Paged Hardware-Monitor Register Bank

This block holds the byte registers of a hardware-monitor I/O space of 256 offsets. A host reaches it over a plain synchronous bus: one cycle with a write strobe, a read strobe, an 8-bit offset and an 8-bit data byte. Most of the space is a window. Offsets 0x10 to 0xFE map into one of sixteen storage pages, and a page-select register at offset 0xFF picks which page that is. A new page number applies from the very next bus cycle.

Window writes are guarded by a host control register at offset 0x04. Bit 0 of this register is a lock. The host clears the lock, writes its window registers, and then sets the lock again. Setting the lock commits the update: the monitor side gets a one-cycle change pulse and sees which page was touched. Reads are never blocked. A power-supply fan duty byte is presented as an output. It always comes from window offset 0x98 of page 0.

Top module: `hwmon_page_bank`

## Requirements
- R1: After reset the lock bit is 1, the page select is 0, and fan_duty, change_pulse, dirty_page and bus_rdata are all 0.
- R2: While the lock bit is 1, a write to a window offset (0x10..0xFE) changes neither the stored byte nor fan_duty.
- R3: While the lock bit is 0, a write to a window offset stores the byte in the selected page. A read issued in cycle t shows its byte on bus_rdata after the clock edge that ends cycle t.
- R4: A write to offset 0xFF sets the page select to wdata[3:0], and the next access uses that page. A read of 0xFF returns the page in bits 3:0, with bits 7:4 equal to zero.
- R5: A write to offset 0x04 sets the lock bit to wdata[0], whatever the lock state. A read of 0x04 returns {7'b0, lock}.
- R6: A write that moves the lock from 0 to 1 drives change_pulse high for exactly one cycle after that edge, and latches the current page into dirty_page. A lock write of 1 while the lock is already 1 gives no pulse. dirty_page changes only together with a pulse.
- R7: fan_duty equals the last accepted write to offset 0x98 of page 0, whatever page is selected. Writes to 0x98 of any other page leave it unchanged.
- R8: Offsets 0x00..0x03 and 0x05..0x0F read as 0x00 and ignore writes.
- R9: A read and a write in the same cycle return the contents as they were before that write. Reads work while the lock is 1.
- R10: bus_rdata holds its value in cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_addr | input | 8 | Byte offset within the space |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| fan_duty | output | 8 | Fan duty byte from page 0, offset 0x98 |
| change_pulse | output | 1 | One-cycle pulse when the lock is set |
| dirty_page | output | 4 | Page selected when the last commit happened |

## Verification
The bench builds the block with its default parameters: sixteen pages, a window from 0x10 to 0xFE, the control register at 0x04 and the fan byte at 0x98. With these values, filling every byte of all sixteen pages is cheap, so random reads can land anywhere and be checked. Random page writes carry nonzero upper nibbles, which exercises the masking in R4. The fan register sits inside page 0, so it can be overwritten both from other pages and while the lock is set, which tests R2 and R7.

// File: rtl/hwmon_pkg.sv
package hwmon_pkg;

    // Decoded kind of a bus offset
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CTRL = 2'd1,
        RGN_PSEL = 2'd2,
        RGN_WIN  = 2'd3
    } region_e;

endpackage

// File: rtl/hwmon_addr_decode.sv
module hwmon_addr_decode
    import hwmon_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CTRL_OFS = 8'h04,
    parameter int PSEL_OFS = 8'hFF,
    parameter int WIN_LO   = 8'h10,
    parameter int WIN_HI   = 8'hFE
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [ADDR_W-1:0] win_idx
);

    always_comb begin
        win_idx = addr - ADDR_W'(WIN_LO);
        if (addr == ADDR_W'(CTRL_OFS))
            region = RGN_CTRL;
        else if (addr == ADDR_W'(PSEL_OFS))
            region = RGN_PSEL;
        else if (addr >= ADDR_W'(WIN_LO) && addr <= ADDR_W'(WIN_HI))
            region = RGN_WIN;
        else
            region = RGN_NONE;
    end

endmodule

// File: rtl/hwmon_page_store.sv
module hwmon_page_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3824,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    // Asynchronous read: returns the pre-write contents in a write cycle
    assign rdata = (int'(idx) < DEPTH) ? mem[idx] : '0;

endmodule

// File: rtl/hwmon_page_bank.sv
module hwmon_page_bank
    import hwmon_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int NUM_PAGES = 16,
    parameter int CTRL_OFS  = 8'h04,
    parameter int PSEL_OFS  = 8'hFF,
    parameter int WIN_LO    = 8'h10,
    parameter int WIN_HI    = 8'hFE,
    parameter int FAN_OFS   = 8'h98,
    localparam int PAGE_W    = $clog2(NUM_PAGES),
    localparam int WIN_DEPTH = WIN_HI - WIN_LO + 1,
    localparam int DEPTH     = NUM_PAGES * WIN_DEPTH,
    localparam int IDX_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] fan_duty,
    output logic              change_pulse,
    output logic [PAGE_W-1:0] dirty_page
);

    typedef struct packed {
        logic              lock;
        logic [PAGE_W-1:0] page;
        logic [DATA_W-1:0] rdata;
        logic              pulse;
        logic [PAGE_W-1:0] dirty;
        logic [DATA_W-1:0] fan;
    } state_t;

    state_t state_d, state_q;

    region_e           region;
    logic [ADDR_W-1:0] win_idx;
    logic [IDX_W-1:0]  flat_idx;
    logic              win_we;
    logic [DATA_W-1:0] win_rdata;

    hwmon_addr_decode #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS),
        .PSEL_OFS(PSEL_OFS),
        .WIN_LO  (WIN_LO),
        .WIN_HI  (WIN_HI)
    ) u_dec (
        .addr   (bus_addr),
        .region (region),
        .win_idx(win_idx)
    );

    hwmon_page_store #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_store (
        .clk  (clk),
        .we   (win_we),
        .idx  (flat_idx),
        .wdata(bus_wdata),
        .rdata(win_rdata)
    );

    always_comb begin
        flat_idx = IDX_W'(state_q.page) * IDX_W'(WIN_DEPTH) + IDX_W'(win_idx);
        win_we   = bus_wr && (region == RGN_WIN) && !state_q.lock;

        state_d       = state_q;
        state_d.pulse = 1'b0;

        if (bus_rd) begin
            unique case (region)
                RGN_CTRL: state_d.rdata = DATA_W'(state_q.lock);
                RGN_PSEL: state_d.rdata = DATA_W'(state_q.page);
                RGN_WIN:  state_d.rdata = win_rdata;
                default:  state_d.rdata = '0;
            endcase
        end

        if (bus_wr) begin
            if (region == RGN_CTRL) begin
                state_d.lock = bus_wdata[0];
                if (bus_wdata[0] && !state_q.lock) begin
                    state_d.pulse = 1'b1;
                    state_d.dirty = state_q.page;
                end
            end
            if (region == RGN_PSEL)
                state_d.page = bus_wdata[PAGE_W-1:0];
            if (win_we && state_q.page == '0 && bus_addr == ADDR_W'(FAN_OFS))
                state_d.fan = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= '0;
            state_q.lock <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata    = state_q.rdata;
    assign fan_duty     = state_q.fan;
    assign change_pulse = state_q.pulse;
    assign dirty_page   = state_q.dirty;

endmodule

// File: rtl/hwmon_page_bank_chk.sv
module hwmon_page_bank_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int PAGE_W   = 4,
    parameter int CTRL_OFS = 8'h04,
    parameter int PSEL_OFS = 8'hFF,
    parameter int WIN_LO   = 8'h10,
    parameter int WIN_HI   = 8'hFE,
    parameter int FAN_OFS  = 8'h98
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] fan_duty,
    input logic              change_pulse,
    input logic [PAGE_W-1:0] dirty_page,
    input logic              lock
);

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        change_pulse |=> !change_pulse); // R6

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(CTRL_OFS) && bus_wdata[0] && !lock) |=> change_pulse); // R6

    AST_DIRTY_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dirty_page) |-> change_pulse); // R6

    AST_FAN_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(FAN_OFS)) |=> $stable(fan_duty)); // R7

    AST_LOCKED_FAN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && bus_wr) |=> $stable(fan_duty)); // R2

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R10

    AST_PAGE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(PSEL_OFS)) |=> (bus_rdata >> PAGE_W) == '0); // R4

    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != ADDR_W'(CTRL_OFS) && bus_addr != ADDR_W'(PSEL_OFS)
         && (bus_addr < ADDR_W'(WIN_LO) || bus_addr > ADDR_W'(WIN_HI))) |=> bus_rdata == '0); // R8

endmodule

bind hwmon_page_bank hwmon_page_bank_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PAGE_W  (PAGE_W),
    .CTRL_OFS(CTRL_OFS),
    .PSEL_OFS(PSEL_OFS),
    .WIN_LO  (WIN_LO),
    .WIN_HI  (WIN_HI),
    .FAN_OFS (FAN_OFS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .fan_duty    (fan_duty),
    .change_pulse(change_pulse),
    .dirty_page  (dirty_page),
    .lock        (state_q.lock)
);

// File: tb/hwmon_page_bank_test.sv
`timescale 1ns/1ps
module hwmon_page_bank_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] fan_duty;
    logic       change_pulse;
    logic [3:0] dirty_page;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    logic [7:0] m_mem [16][256];
    logic       m_lock = 1'b1;
    logic [3:0] m_page = '0;
    logic [7:0] m_fan = '0;
    logic [3:0] m_dirty = '0;
    logic [7:0] m_last = '0;

    always #2.5 clk = ~clk;

    hwmon_page_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fan_duty(fan_duty), .change_pulse(change_pulse), .dirty_page(dirty_page)
    );

    function automatic logic is_win(input logic [7:0] a);
        return a >= 8'h10 && a <= 8'hFE;
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'h04) return {7'b0, m_lock};
        if (a == 8'hFF) return {4'b0, m_page};
        if (is_win(a))  return m_mem[m_page][a];
        return 8'h00;
    endfunction

    function automatic string req_of(input logic [7:0] a);
        if (a == 8'h04) return "R5";
        if (a == 8'hFF) return "R4";
        if (is_win(a))  return "R3";
        return "R8";
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus cycle; checks every output after the edge that ends it
    task automatic op(input logic w, input logic r, input logic [7:0] a,
                      input logic [7:0] d, input string req);
        logic [7:0] exp_rd;
        logic       exp_pulse;
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        exp_rd    = model_read(a);
        exp_pulse = w && a == 8'h04 && d[0] && !m_lock;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
        if (w) begin
            if (a == 8'h04) begin
                if (exp_pulse) m_dirty = m_page;
                m_lock = d[0];
            end else if (a == 8'hFF) begin
                m_page = d[3:0];
            end else if (is_win(a) && !m_lock) begin
                m_mem[m_page][a] = d;
                if (m_page == 4'd0 && a == 8'h98) m_fan = d;
            end
        end
        if (r) begin
            chk(req, bus_rdata, exp_rd);
            m_last = exp_rd;
        end else begin
            chk("R10", bus_rdata, m_last);
        end
        chk("R6", {7'b0, change_pulse}, {7'b0, exp_pulse});
        chk("R6", {4'b0, dirty_page}, {4'b0, m_dirty});
        chk("R7", fan_duty, m_fan);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", bus_rdata, 8'h00);
        chk("R1", fan_duty, 8'h00);
        chk("R1", {7'b0, change_pulse}, 8'h00);
        chk("R1", {4'b0, dirty_page}, 8'h00);
        op(0, 1, 8'h04, 8'h00, "R1");
        op(0, 1, 8'hFF, 8'h00, "R1");

        // R3: fill every page while unlocked
        op(1, 0, 8'h04, 8'h00, "R5");
        for (int p = 0; p < 16; p++) begin
            op(1, 0, 8'hFF, 8'(p), "R4");
            for (int o = 16'h10; o <= 16'hFE; o++)
                op(1, 0, 8'(o), 8'(p * 17 + o) ^ 8'h5A, "R3");
        end
        op(0, 1, 8'h98, 8'h00, "R3");

        // R6: commit from page 15 latches dirty page; repeat set gives no pulse
        op(1, 0, 8'h04, 8'h01, "R6");
        chk("R6", {4'b0, dirty_page}, 8'h0F);
        op(1, 0, 8'h04, 8'h01, "R6");

        // R2: locked window write is dropped, including page 0 fan byte
        op(1, 0, 8'hFF, 8'h00, "R4");
        op(1, 0, 8'h98, 8'hC3, "R2");
        op(0, 1, 8'h98, 8'h00, "R2");
        op(1, 0, 8'h40, 8'hEE, "R2");
        op(0, 1, 8'h40, 8'h00, "R2");

        // R4: upper nibble ignored, new page used on the next access
        op(1, 0, 8'hFF, 8'hA5, "R4");
        op(0, 1, 8'hFF, 8'h00, "R4");
        op(0, 1, 8'h20, 8'h00, "R4");

        // R7: fan byte of page 5 does not reach fan_duty; page 0 does
        op(1, 0, 8'h04, 8'h00, "R5");
        op(1, 0, 8'h98, 8'h11, "R7");
        op(1, 0, 8'hFF, 8'h00, "R4");
        op(1, 0, 8'h98, 8'h77, "R7");
        chk("R7", fan_duty, 8'h77);

        // R9: read with simultaneous write returns old byte
        op(1, 1, 8'h30, 8'h99, "R9");
        op(0, 1, 8'h30, 8'h00, "R9");

        // R8: holes read zero, writes ignored
        op(1, 0, 8'h07, 8'hFF, "R8");
        op(0, 1, 8'h07, 8'h00, "R8");
        op(0, 1, 8'h00, 8'h00, "R8");
        op(0, 1, 8'h0F, 8'h00, "R8");

        // R10: no read keeps the last byte
        op(0, 0, 8'h30, 8'h00, "R10");
        op(1, 0, 8'h04, 8'h01, "R6");

        // Random mix
        for (int i = 0; i < 6000; i++) begin
            int unsigned k;
            logic [7:0]  a;
            logic        w;
            logic        r;
            k = $urandom_range(0, 99);
            if (k < 12)      a = 8'h04;
            else if (k < 22) a = 8'hFF;
            else if (k < 30) a = 8'($urandom_range(0, 15));
            else if (k < 40) a = 8'h98;
            else             a = 8'($urandom_range(16'h10, 16'hFE));
            w = 1'($urandom_range(0, 1));
            r = 1'($urandom_range(0, 2) != 0);
            op(w, r, a, 8'($urandom), req_of(a));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule